// File: doc/BRIEF.md
# Multi-Endpoint Packet Buffer Window

This block holds one packet buffer per endpoint and lets a processor reach all of them through a single shared data register. The processor first writes an endpoint number into a select register. Every later access to the data register then goes to that endpoint's buffer. Each endpoint keeps its own read pointer and write pointer, so moving the select value between endpoints never loses a position.

On the receive side, a packet engine presents bytes with a valid strobe, an endpoint number and an end-of-packet marker. The bytes are stored from position zero onward. At a good end of packet, that endpoint's byte count is loaded with the packet length and its pointers are cleared. The processor drains the packet by reading the data register repeatedly, and the byte count stays fixed while it does so.

Bytes the processor writes to the data register fill the endpoint buffer for a later transmitter. That transmitter reads them back through a combinational peek port, and the fill level can be read in the control register. Writes beyond capacity are dropped and raise a sticky per-endpoint overflow flag.

Top module: `pktwin_top`

## Requirements
- R1: After reset the select register reads 0, and every endpoint has byte count 0, read and write pointers at 0 and overflow flag 0. The read-data output is 0.
- R2: Register addresses are 0 select, 1 data, 2 byte count and 3 control/status. Writing the select register with a value below NUM_EP stores it, and it reads back zero-extended. A value of NUM_EP or more is ignored.
- R3: A packet ended with rx_eop high and rx_bad low stores its bytes at positions 0, 1, 2 and onward of the endpoint given by rx_ep. The byte count, read one cycle after the strobe, becomes min(length, DEPTH). Bytes past DEPTH are discarded, and both pointers of that endpoint return to 0.
- R4: A packet whose last byte carries rx_bad high leaves the endpoint's byte count and pointers unchanged.
- R5: A read strobe at address 1 returns, on bus_rdata in the following cycle, the byte at the selected endpoint's read pointer, and advances that pointer by one.
- R6: A data read never changes the byte count. When the read pointer equals the byte count, the read returns 0 and the pointer stays put.
- R7: A write strobe at address 1 stores bus_wdata at the selected endpoint's write pointer and advances that pointer, leaving the byte count unchanged. The stored byte appears on tx_data when tx_ep and tx_addr point at it. Reading address 3 returns the write pointer in bits [CNT_W-1:0].
- R8: A data write while the write pointer equals DEPTH is dropped and sets that endpoint's overflow flag, seen in bit DATA_W-1 of address 3. Writing address 3 with bit 1 set clears the flag.
- R9: The pointers of endpoints that are not selected keep their values across select changes and across accesses to other endpoints.
- R10: Writing address 3 with bit 0 set clears both pointers of the selected endpoint and keeps its byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Processor write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after bus_rd |
| rx_valid | input | 1 | Received byte valid |
| rx_eop | input | 1 | Marks the last byte of a packet |
| rx_bad | input | 1 | With rx_eop, rejects the packet |
| rx_ep | input | EP_W | Destination endpoint of the received byte |
| rx_data | input | DATA_W | Received byte |
| tx_ep | input | EP_W | Endpoint for the transmit peek |
| tx_addr | input | AW | Byte position for the transmit peek |
| tx_data | output | DATA_W | Buffer byte at tx_ep/tx_addr, combinational |

## Verification
The assertions take for granted that the receive engine and the processor never write the same endpoint buffer in the same cycle. They also assume rx_ep holds steady for the whole of a packet, and that bus_rd and bus_wr are never high together. The bench meets these conditions by running packet reception and bus accesses as separate, sequential tasks, and by holding the endpoint number constant for the length of each packet. Random select values include the illegal value, and random packet lengths run past DEPTH. This drives the clamp, overflow and empty-read paths without breaking those assumptions.

// File: rtl/pktwin_pkg.sv
package pktwin_pkg;

  // Register map; the address values are what the bus decodes.
  typedef enum logic [1:0] {
    REG_SEL   = 2'd0,
    REG_DATA  = 2'd1,
    REG_COUNT = 2'd2,
    REG_CTRL  = 2'd3
  } reg_addr_e;

  // Control register command bits.
  localparam int CTRL_PTR_CLR_BIT = 0;
  localparam int CTRL_OVF_CLR_BIT = 1;

endpackage

// File: rtl/pktwin_rx_ctrl.sv
module pktwin_rx_ctrl #(
  parameter int NUM_EP = 3,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_eop,
  input  logic              rx_bad,
  input  logic [EP_W-1:0]   rx_ep,
  input  logic [DATA_W-1:0] rx_data,
  output logic              store_en,
  output logic [EP_W-1:0]   store_ep,
  output logic [AW-1:0]     store_addr,
  output logic [DATA_W-1:0] store_data,
  output logic              commit_en,
  output logic [CNT_W-1:0]  commit_len
);

  // Length reached after accepting the byte at position idx, clamped to capacity.
  function automatic logic [CNT_W-1:0] len_after(input logic [CNT_W-1:0] idx);
    if (idx < CNT_W'(DEPTH)) return idx + 1'b1;
    return CNT_W'(DEPTH);
  endfunction

  logic [CNT_W-1:0] idx;
  logic             ep_ok;
  logic             room;

  assign ep_ok      = (int'(rx_ep) < NUM_EP);
  assign room       = (idx < CNT_W'(DEPTH));
  assign store_en   = rx_valid && ep_ok && room;
  assign store_ep   = rx_ep;
  assign store_addr = idx[AW-1:0];
  assign store_data = rx_data;
  assign commit_en  = rx_valid && rx_eop && !rx_bad && ep_ok;
  assign commit_len = len_after(idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (rx_valid) begin
      if (rx_eop)    idx <= '0;
      else if (room) idx <= idx + 1'b1;
    end
  end

  assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> (commit_len != '0) && (commit_len <= CNT_W'(DEPTH)));

  assert_idx_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_eop) |=> (idx == '0));

  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= CNT_W'(DEPTH));

endmodule

// File: rtl/pktwin_ep_buf.sv
module pktwin_ep_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              ptr_clr,
  input  logic              ovf_clr,
  input  logic              rx_we,
  input  logic [AW-1:0]     rx_addr,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_commit,
  input  logic [CNT_W-1:0]  rx_len,
  input  logic [AW-1:0]     peek_addr,
  output logic [DATA_W-1:0] peek_data,
  output logic [DATA_W-1:0] rd_byte,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic [CNT_W-1:0]  fill,
  output logic              ovf
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  rd_ptr;
  logic [CNT_W-1:0]  wr_ptr;

  // Named events used by the assertions below.
  logic rd_avail;
  logic rd_hit;
  logic wr_hit;
  logic wr_spill;
  logic ptr_restart;

  assign rd_avail    = (rd_ptr < byte_cnt);
  assign rd_hit      = cpu_rd && rd_avail;
  assign wr_hit      = cpu_wr && (wr_ptr < CNT_W'(DEPTH));
  assign wr_spill    = cpu_wr && !wr_hit;
  assign ptr_restart = rx_commit || ptr_clr;

  assign rd_byte   = rd_avail ? mem[rd_ptr[AW-1:0]] : '0;
  assign peek_data = mem[peek_addr];
  assign fill      = wr_ptr;

  always_ff @(posedge clk) begin
    if (rx_we)       mem[rx_addr]          <= rx_wdata;
    else if (wr_hit) mem[wr_ptr[AW-1:0]]   <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else if (ptr_restart) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      if (rd_hit) rd_ptr <= rd_ptr + 1'b1;
      if (wr_hit) wr_ptr <= wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         byte_cnt <= '0;
    else if (rx_commit) byte_cnt <= rx_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ovf <= 1'b0;
    else if (wr_spill) ovf <= 1'b1;
    else if (ovf_clr)  ovf <= 1'b0;
  end

  assert_no_port_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_we && cpu_wr));

  assert_cnt_hold_on_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_rd || cpu_wr) && !rx_commit) |=> $stable(byte_cnt));

  assert_rd_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !ptr_restart) |=> (rd_ptr == $past(rd_ptr) + 1'b1));

  assert_rd_empty_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !rd_avail && !ptr_restart) |=> $stable(rd_ptr));

  assert_rd_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= byte_cnt);

  assert_wr_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= CNT_W'(DEPTH));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_spill |=> ovf);

  assert_ptr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (rd_ptr == '0) && (wr_ptr == '0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd && !cpu_wr && !ptr_restart) |=> ($stable(rd_ptr) && $stable(wr_ptr)));

endmodule

// File: rtl/pktwin_top.sv
module pktwin_top
  import pktwin_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic              rx_eop,
  input  logic              rx_bad,
  input  logic [EP_W-1:0]   rx_ep,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [EP_W-1:0]   tx_ep,
  input  logic [AW-1:0]     tx_addr,
  output logic [DATA_W-1:0] tx_data
);

  // Status word: write pointer in the low bits, overflow flag in the top bit.
  function automatic logic [DATA_W-1:0] status_word(input logic [CNT_W-1:0] lvl,
                                                     input logic          flag);
    logic [DATA_W-1:0] w;
    w = DATA_W'(lvl);
    w[DATA_W-1] = flag;
    return w;
  endfunction

  reg_addr_e          addr;
  logic [EP_W-1:0]    sel;
  logic               sel_wr;
  logic               sel_legal;
  logic               data_rd;
  logic               data_wr;
  logic               ctrl_wr;

  logic               st_en;
  logic [EP_W-1:0]    st_ep;
  logic [AW-1:0]      st_addr;
  logic [DATA_W-1:0]  st_data;
  logic               cm_en;
  logic [CNT_W-1:0]   cm_len;

  logic [DATA_W-1:0]  rd_byte_v [NUM_EP];
  logic [DATA_W-1:0]  peek_v    [NUM_EP];
  logic [CNT_W-1:0]   cnt_v     [NUM_EP];
  logic [CNT_W-1:0]   fill_v    [NUM_EP];
  logic [NUM_EP-1:0]  ovf_v;

  assign addr      = reg_addr_e'(bus_addr);
  assign sel_legal = (bus_wdata < DATA_W'(NUM_EP));
  assign sel_wr    = bus_wr && (addr == REG_SEL);
  assign data_rd   = bus_rd && (addr == REG_DATA);
  assign data_wr   = bus_wr && (addr == REG_DATA);
  assign ctrl_wr   = bus_wr && (addr == REG_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n)                  sel <= '0;
    else if (sel_wr && sel_legal) sel <= bus_wdata[EP_W-1:0];
  end

  pktwin_rx_ctrl #(
    .NUM_EP (NUM_EP),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_eop     (rx_eop),
    .rx_bad     (rx_bad),
    .rx_ep      (rx_ep),
    .rx_data    (rx_data),
    .store_en   (st_en),
    .store_ep   (st_ep),
    .store_addr (st_addr),
    .store_data (st_data),
    .commit_en  (cm_en),
    .commit_len (cm_len)
  );

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic is_sel;
    logic is_rx;
    assign is_sel = (sel == EP_W'(e));
    assign is_rx  = (st_ep == EP_W'(e));

    pktwin_ep_buf #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
    ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_rd    (data_rd && is_sel),
      .cpu_wr    (data_wr && is_sel),
      .cpu_wdata (bus_wdata),
      .ptr_clr   (ctrl_wr && is_sel && bus_wdata[CTRL_PTR_CLR_BIT]),
      .ovf_clr   (ctrl_wr && is_sel && bus_wdata[CTRL_OVF_CLR_BIT]),
      .rx_we     (st_en && is_rx),
      .rx_addr   (st_addr),
      .rx_wdata  (st_data),
      .rx_commit (cm_en && is_rx),
      .rx_len    (cm_len),
      .peek_addr (tx_addr),
      .peek_data (peek_v[e]),
      .rd_byte   (rd_byte_v[e]),
      .byte_cnt  (cnt_v[e]),
      .fill      (fill_v[e]),
      .ovf       (ovf_v[e])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (addr)
        REG_SEL:   bus_rdata <= DATA_W'(sel);
        REG_DATA:  bus_rdata <= rd_byte_v[sel];
        REG_COUNT: bus_rdata <= DATA_W'(cnt_v[sel]);
        REG_CTRL:  bus_rdata <= status_word(fill_v[sel], ovf_v[sel]);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  assign tx_data = (int'(tx_ep) < NUM_EP) ? peek_v[tx_ep] : '0;

  assert_sel_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel) < NUM_EP);

  assert_sel_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !sel_legal) |=> $stable(sel));

  assert_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/tb_pktwin_top.sv
module tb_pktwin_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 3;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int EP_W   = 2;
  localparam int AW     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_rdata;
  logic              rx_valid = 1'b0;
  logic              rx_eop = 1'b0;
  logic              rx_bad = 1'b0;
  logic [EP_W-1:0]   rx_ep = '0;
  logic [DATA_W-1:0] rx_data = '0;
  logic [EP_W-1:0]   tx_ep = '0;
  logic [AW-1:0]     tx_addr = '0;
  logic [DATA_W-1:0] tx_data;

  pktwin_top #(.NUM_EP(NUM_EP), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_eop(rx_eop), .rx_bad(rx_bad), .rx_ep(rx_ep), .rx_data(rx_data),
    .tx_ep(tx_ep), .tx_addr(tx_addr), .tx_data(tx_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  int m_mem [NUM_EP][DEPTH];
  int m_cnt [NUM_EP];
  int m_rd  [NUM_EP];
  int m_wr  [NUM_EP];
  bit m_ovf [NUM_EP];
  int m_sel;

  function automatic int exp_len(int n);
    return (n > DEPTH) ? DEPTH : n;
  endfunction

  function automatic int exp_status(int lvl, bit flag);
    return lvl + (flag ? (1 << (DATA_W - 1)) : 0);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_write(int a, int d);
    @(negedge clk);
    bus_addr = 2'(a); bus_wdata = DATA_W'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(int a, output int d);
    @(negedge clk);
    bus_addr = 2'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic select_ep(int ep);
    bus_write(0, ep);
    if (ep < NUM_EP) m_sel = ep;
  endtask

  task automatic send_pkt(int ep, int len, bit bad);
    for (int i = 0; i < len; i++) begin
      int b;
      b = int'($urandom_range(255, 0));
      @(negedge clk);
      rx_valid = 1'b1; rx_ep = EP_W'(ep); rx_data = DATA_W'(b);
      rx_eop = (i == len - 1); rx_bad = bad && (i == len - 1);
      if (i < DEPTH) m_mem[ep][i] = b;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_eop = 1'b0; rx_bad = 1'b0;
    if (!bad) begin
      m_cnt[ep] = exp_len(len); m_rd[ep] = 0; m_wr[ep] = 0;
    end
  endtask

  task automatic read_data(string req);
    int d, e;
    bus_read(1, d);
    if (m_rd[m_sel] < m_cnt[m_sel]) begin
      e = m_mem[m_sel][m_rd[m_sel]];
      m_rd[m_sel]++;
    end else begin
      e = 0;
    end
    check(req, "data read", d, e);
  endtask

  task automatic write_data(int b);
    bus_write(1, b);
    if (m_wr[m_sel] < DEPTH) begin
      m_mem[m_sel][m_wr[m_sel]] = b & 255;
      m_wr[m_sel]++;
    end else begin
      m_ovf[m_sel] = 1'b1;
    end
  endtask

  task automatic check_count(string req);
    int d;
    bus_read(2, d);
    check(req, "byte count", d, m_cnt[m_sel]);
  endtask

  task automatic check_status(string req);
    int d;
    bus_read(3, d);
    check(req, "status", d, exp_status(m_wr[m_sel], m_ovf[m_sel]));
  endtask

  task automatic check_peek(string req, int ep, int pos);
    @(negedge clk);
    tx_ep = EP_W'(ep); tx_addr = AW'(pos);
    #1;
    check(req, "tx peek", int'(tx_data), m_mem[ep][pos]);
  endtask

  task automatic ctrl(int v);
    bus_write(3, v);
    if (v[0]) begin m_rd[m_sel] = 0; m_wr[m_sel] = 0; end
    if (v[1] && m_ovf[m_sel]) m_ovf[m_sel] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d;
    void'($urandom(32'h5EED_0C1A));
    for (int e = 0; e < NUM_EP; e++) begin
      m_cnt[e] = 0; m_rd[e] = 0; m_wr[e] = 0; m_ovf[e] = 0;
      for (int i = 0; i < DEPTH; i++) m_mem[e][i] = 0;
    end
    m_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "rdata after reset", int'(bus_rdata), 0);
    bus_read(0, d); check("R1", "select after reset", d, 0);
    for (int e = 0; e < NUM_EP; e++) begin
      select_ep(e);
      check_count("R1");
      check_status("R1");
    end

    // R2 select legality
    select_ep(1);
    select_ep(3);
    bus_read(0, d); check("R2", "illegal select ignored", d, 1);
    select_ep(2);
    bus_read(0, d); check("R2", "select readback", d, 2);

    // R3, R5, R6 packet drain on endpoint 2
    send_pkt(2, 5, 0);
    check_count("R3");
    for (int i = 0; i < 5; i++) read_data("R5");
    read_data("R6");
    read_data("R6");
    check_count("R6");

    // R3 clamp of long packet on endpoint 1
    send_pkt(1, DEPTH + 4, 0);
    select_ep(1);
    check_count("R3");

    // R9 interleave endpoints 1 and 2
    read_data("R9"); read_data("R9");
    send_pkt(2, 7, 0);
    select_ep(2);
    read_data("R9"); read_data("R9"); read_data("R9");
    select_ep(1);
    read_data("R9"); read_data("R9");
    select_ep(2);
    read_data("R9");

    // R4 bad packet keeps count and pointer
    send_pkt(2, 3, 1);
    check_count("R4");
    read_data("R4");

    // R7 writes to endpoint 0
    select_ep(0);
    for (int i = 0; i < 3; i++) write_data(int'($urandom_range(255, 0)));
    check_status("R7");
    check_count("R7");
    for (int i = 0; i < 3; i++) check_peek("R7", 0, i);

    // R8 overflow
    for (int i = 0; i < DEPTH; i++) write_data(i * 7 + 1);
    check_status("R8");
    check_peek("R8", 0, DEPTH - 1);
    ctrl(2);
    check_status("R8");

    // R10 pointer clear keeps count
    select_ep(1);
    ctrl(1);
    check_count("R10");
    read_data("R10");
    check_status("R10");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(7, 0));
      case (op)
        0: send_pkt(int'($urandom_range(NUM_EP - 1, 0)), int'($urandom_range(DEPTH + 4, 1)),
                    ($urandom_range(4, 0) == 0));
        1: begin
             select_ep(int'($urandom_range(NUM_EP, 0)));
             bus_read(0, d); check("R2", "random select", d, m_sel);
           end
        2, 3: read_data("R5");
        4: write_data(int'($urandom_range(255, 0)));
        5: begin check_count("R6"); check_status("R8"); end
        6: ctrl(int'($urandom_range(3, 0)));
        default: begin
          if (m_wr[m_sel] > 0) check_peek("R7", m_sel, int'($urandom_range(m_wr[m_sel] - 1, 0)));
          else check_count("R3");
        end
      endcase
    end

    finish_run();
  end

endmodule